// File: doc/BRIEF.md
# Stereo PCM Frame Serializer

This block turns pairs of 16-bit stereo samples into a continuous framed serial bit stream. All of its timing comes from one master clock (nominally 11.2896 MHz). An internal divider produces a bit strobe every four master cycles, which gives a 2.8224 MHz bit rate. Every 64 bit slots it starts a new frame, so a frame lasts 256 master cycles and the frame rate is 44.1 kHz.

Each frame is sent most significant bit first, in this order:

- a 16-bit sync word;
- the left sample;
- the right sample;
- one odd-parity bit for each channel;
- 14 bits of auxiliary subcode.

A producer offers samples on a parallel port with a one-cycle valid strobe at any time during a frame. The latest offer is taken at the next frame boundary. If a frame period passes with no offer, the previous sample is sent again and a sticky flag records the underrun.

Top module: `pcm_frame_tx`

## Requirements
- R1: Each bit slot lasts exactly 4 master cycles, and `ser_o` changes only when a new slot begins.
- R2: A frame is 64 slots (256 master cycles). `fsync_o` is high for exactly one master cycle, the first cycle of slot 0. The first `fsync_o` pulse appears on the 4th rising edge after reset is released.
- R3: Slots 0 to 15 carry the pattern 1111111100000000, with slot 0 holding the first 1.
- R4: Slots 16 to 31 carry the left sample and slots 32 to 47 carry the right sample. Each sample is sent MSB first, so bit 15 is in slot 16 (left) and in slot 32 (right).
- R5: Slot 48 is the left parity bit and slot 49 is the right parity bit. Each parity bit is chosen so that the 16 sample bits plus that bit hold an odd number of ones.
- R6: Slots 50 to 63 carry `sub_i` MSB first, with `sub_i[13]` in slot 50.
- R7: A cycle with `valid_i` high offers `left_i`, `right_i` and `sub_i`. The last offer made at or before the rising edge that starts a frame is the one sent in that frame. This includes an offer made in the cycle that ends exactly at that edge.
- R8: If no offer was made since the previous frame start, the frame repeats the previous values and `underrun_o` goes high. `underrun_o` stays high until reset.
- R9: Synchronous active-high reset drives `ser_o`, `fsync_o` and `underrun_o` low and clears the held sample. As a result, the first frame after reset with no offer carries zero audio, zero subcode and both parity bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| left_i | input | 16 | Left-channel sample |
| right_i | input | 16 | Right-channel sample |
| sub_i | input | 14 | Subcode bits offered with the sample |
| valid_i | input | 1 | Offers the sample inputs in this cycle |
| ser_o | output | 1 | Serial frame data |
| fsync_o | output | 1 | One-cycle strobe at the start of slot 0 |
| underrun_o | output | 1 | Sticky flag: a frame went out without a new sample |

## Verification
The serial bit of slot k goes out on the rising edge 4·k master cycles after the edge that raises `fsync_o`. It holds for four cycles, and the next `fsync_o` arrives 256 cycles after the previous one. The first `fsync_o` comes 4 cycles after reset is released. The bench aligns on `fsync_o` at a falling edge and then reads one bit per four falling edges. It checks the held value at the three falling edges in between and confirms `fsync_o` again exactly 256 falling edges later. A sample offered during frame n appears in frame n+1. `underrun_o` is checked at the `fsync_o` of the frame whose start edge found no offer.

// File: rtl/pcm_frame_tx.sv
module pcm_frame_tx #(
  parameter int SAMPLE_W = 16,
  parameter int SUB_W = 14,
  parameter int BIT_DIV = 4,
  parameter int SYNC_W = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hFF00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic [SUB_W-1:0]    sub_i,
  input  logic                valid_i,
  output logic                ser_o,
  output logic                fsync_o,
  output logic                underrun_o
);
  localparam int FRAME_W = SYNC_W + 2*SAMPLE_W + 2 + SUB_W;
  localparam int DIV_BW  = $clog2(BIT_DIV);
  localparam int SLOT_BW = $clog2(FRAME_W);

  logic [DIV_BW-1:0]   div_q;
  logic [SLOT_BW-1:0]  slot_q;
  logic [FRAME_W-2:0]  sh_q;
  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic [SUB_W-1:0]    hold_s;
  logic                fresh_q;

  logic bit_en, frame_start;
  logic [SAMPLE_W-1:0] sel_l, sel_r;
  logic [SUB_W-1:0]    sel_s;
  logic [FRAME_W-1:0]  frame_w;

  assign bit_en      = (div_q == DIV_BW'(BIT_DIV-1));
  assign frame_start = bit_en && (slot_q == SLOT_BW'(FRAME_W-1));
  assign sel_l   = valid_i ? left_i  : hold_l;
  assign sel_r   = valid_i ? right_i : hold_r;
  assign sel_s   = valid_i ? sub_i   : hold_s;
  assign frame_w = {SYNC_WORD, sel_l, sel_r, ~^sel_l, ~^sel_r, sel_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q      <= '0;
      slot_q     <= SLOT_BW'(FRAME_W-1);
      sh_q       <= '0;
      hold_l     <= '0;
      hold_r     <= '0;
      hold_s     <= '0;
      fresh_q    <= 1'b0;
      ser_o      <= 1'b0;
      fsync_o    <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      fsync_o <= frame_start;
      div_q   <= bit_en ? '0 : div_q + 1'b1;
      if (bit_en)
        slot_q <= frame_start ? '0 : slot_q + 1'b1;
      if (valid_i) begin
        hold_l  <= left_i;
        hold_r  <= right_i;
        hold_s  <= sub_i;
        fresh_q <= 1'b1;
      end
      if (frame_start) begin
        ser_o   <= frame_w[FRAME_W-1];
        sh_q    <= frame_w[FRAME_W-2:0];
        fresh_q <= 1'b0;
        if (!valid_i && !fresh_q)
          underrun_o <= 1'b1;
      end else if (bit_en) begin
        ser_o <= sh_q[FRAME_W-2];
        sh_q  <= {sh_q[FRAME_W-3:0], 1'b0};
      end
    end
  end

  p_ser_steady_r1: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(ser_o));
  p_sync_single_r2: assert property (@(posedge clk) disable iff (rst)
    fsync_o |=> !fsync_o);
  p_sync_origin_r2: assert property (@(posedge clk) disable iff (rst)
    fsync_o |-> (slot_q == '0) && (div_q == '0));
  p_sync_lead_r3: assert property (@(posedge clk) disable iff (rst)
    fsync_o |-> ser_o == SYNC_WORD[SYNC_W-1]);
  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    underrun_o |=> underrun_o);
endmodule

// File: tb/sim_pcm_frame_tx.sv
module sim_pcm_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [45:0] VEC [NV] = '{
    {16'h0000, 16'hFFFF, 14'h0000},
    {16'h8001, 16'h7FFE, 14'h3FFF},
    {16'hA5A5, 16'h5A5A, 14'h1555},
    {16'h0001, 16'h0003, 14'h2AAA},
    {16'h1234, 16'hFEDC, 14'h0F0F},
    {16'hFFFF, 16'h0000, 14'h0001}
  };

  logic clk = 0, rst = 1, valid_i = 0;
  logic [15:0] left_i = '0, right_i = '0;
  logic [13:0] sub_i = '0;
  logic ser_o, fsync_o, underrun_o;
  int total = 0, bad = 0;
  bit done = 0;

  pcm_frame_tx u0 (.clk(clk), .rst(rst), .left_i(left_i), .right_i(right_i),
    .sub_i(sub_i), .valid_i(valid_i), .ser_o(ser_o), .fsync_o(fsync_o),
    .underrun_o(underrun_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic odd_bit(input logic [15:0] v);
    int n = 0;
    for (int k = 0; k < 16; k++) n += int'(v[k]);
    return (n % 2 == 0);
  endfunction

  function automatic logic [63:0] expect_frame(input logic [45:0] v);
    return {16'hFF00, v[45:30], v[29:14], odd_bit(v[45:30]), odd_bit(v[29:14]), v[13:0]};
  endfunction

  task automatic get_frame(output logic [63:0] f, output bit steady, output bit gap_ok);
    steady = 1;
    for (int s = 0; s < 64; s++) begin
      logic b;
      b = ser_o;
      f[63-s] = b;
      for (int c = 0; c < 4; c++) begin
        if (c > 0 && ser_o !== b) steady = 0;
        if (!(s == 0 && c == 0) && fsync_o !== 1'b0) steady = 0;
        @(negedge clk);
      end
    end
    gap_ok = (fsync_o === 1'b1);
  endtask

  task automatic pulse(input logic [45:0] v, input int dly);
    repeat (dly) @(negedge clk);
    {left_i, right_i, sub_i} = v;
    valid_i = 1;
    @(negedge clk);
    valid_i = 0;
  endtask

  task automatic check_frame(input logic [63:0] f, input logic [45:0] v, input string tag);
    logic [63:0] e;
    e = expect_frame(v);
    check(f[63:48] == e[63:48], {"R3 sync ", tag}, 64'(f[63:48]), 64'(e[63:48]));
    check(f[47:16] == e[47:16], {"R4 audio ", tag}, 64'(f[47:16]), 64'(e[47:16]));
    check(f[15:14] == e[15:14], {"R5 parity ", tag}, 64'(f[15:14]), 64'(e[15:14]));
    check(f[13:0] == e[13:0], {"R6 subcode ", tag}, 64'(f[13:0]), 64'(e[13:0]));
  endtask

  task automatic frame_meta(input bit steady, input bit gap_ok);
    check(steady, "R1 slot hold / fsync width", 64'(steady), 64'd1);
    check(gap_ok, "R2 fsync period 256", 64'(gap_ok), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] f;
    bit st, gp;
    int n;
    repeat (3) @(negedge clk);
    check({ser_o, fsync_o, underrun_o} == 3'b000, "R9 reset outputs", 64'({ser_o, fsync_o, underrun_o}), 64'd0);
    rst = 0;
    {left_i, right_i, sub_i} = VEC[0];
    valid_i = 1;
    n = 0;
    @(negedge clk); n++;
    valid_i = 0;
    while (!fsync_o && n < 10) begin @(negedge clk); n++; end
    check(n == 4, "R2 first fsync delay", 64'(n), 64'd4);

    for (int i = 0; i < NV; i++) begin
      check(underrun_o == 1'b0, "R8 no underrun when fed", 64'(underrun_o), 64'd0);
      fork
        get_frame(f, st, gp);
        if (i + 1 < NV) pulse(VEC[i+1], 0);
      join
      check_frame(f, VEC[i], $sformatf("vec%0d", i));
      frame_meta(st, gp);
    end

    check(underrun_o == 1'b1, "R8 underrun set", 64'(underrun_o), 64'd1);
    fork
      get_frame(f, st, gp);
      begin pulse(VEC[2], 10); pulse(VEC[3], 244); end
    join
    check(f == expect_frame(VEC[NV-1]), "R8 repeated sample", f, expect_frame(VEC[NV-1]));
    frame_meta(st, gp);
    get_frame(f, st, gp);
    check(f == expect_frame(VEC[3]), "R7 latest offer at boundary", f, expect_frame(VEC[3]));
    check(underrun_o == 1'b1, "R8 underrun sticky", 64'(underrun_o), 64'd1);

    rst = 1;
    @(negedge clk); @(negedge clk);
    check({ser_o, fsync_o, underrun_o} == 3'b000, "R9 mid-run reset", 64'({ser_o, fsync_o, underrun_o}), 64'd0);
    rst = 0;
    n = 0;
    while (!fsync_o && n < 10) begin @(negedge clk); n++; end
    check(n == 4, "R2 fsync delay after reset", 64'(n), 64'd4);
    check(underrun_o == 1'b1, "R8 underrun on empty first frame", 64'(underrun_o), 64'd1);
    get_frame(f, st, gp);
    check_frame(f, 46'd0, "R9 cleared hold");
    frame_meta(st, gp);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule